// File: doc/BRIEF.md
# Four-Bit Arithmetic and Logic Slice

This block is a purely combinational slice that operates on two operands of `WIDTH` bits (four by default). A five-bit operation selector drives it. The top selector bit chooses between two families of operation. In the logic family, the low four selector bits act as the truth table of a two-input Boolean function, and that function is applied to every bit pair on its own. In the arithmetic family, the low four bits pick one of sixteen codes. These cover addition, subtraction in both operand orders, increment, decrement, negation of either operand, doubling and three constants.

Every arithmetic code feeds a single adder. The adder sees an x term, a y term and a carry into bit 0, and the operation decides all three. This makes the carry-out and the group generate/propagate outputs meaningful for every arithmetic code. Wider words can be built in two ways. One is to chain the carry-out of a lower slice into the carry-in of the next. The other is to feed each slice's group generate and propagate into an external lookahead network.

Top module: `alu_slice`

## Requirements
- R1: `opSel[4]` = 0 selects the logic family and `opSel[4]` = 1 selects the arithmetic family; the low four bits `opSel[3:0]` are the code within the family.
- R2: In the logic family, `result[i]` = `opSel[{aIn[i],bIn[i]}]`, where the index is 2·a+b. Examples: code 4'b1000 is AND, 4'b1110 is OR, 4'b0110 is XOR, 4'b0101 is NOT B. No carry passes between bit positions.
- R3: In the logic family, `carryOut`, `grpGen` and `grpProp` are all 0, and `carryIn` has no effect on any output.
- R4: Arithmetic code 0 gives A+B+carryIn and code 7 gives A+A+carryIn. `carryOut` is the carry out of the top bit.
- R5: Arithmetic code 1 gives A + ~B + carryIn. With carryIn=1 this is A−B in two's complement, and `carryOut`=1 means no borrow.
- R6: Five codes ignore carryIn and use these adder forms: code 2 is A+1 (A+0+1), code 3 is A−1 (A+all-ones+0), code 4 is −A (~A+0+1), code 5 is B−A (B+~A+1) and code 6 is −B (0+~B+1).
- R7: Three codes give constants and ignore carryIn: code 8 gives 0 (0+0+0), code 9 gives +1 (0+0+1) and code 10 gives −1 (all-ones+0+0). Codes 11 to 15 give result 0 with `carryOut`, `grpGen` and `grpProp` all 0 except as the 0+0+0 form implies.
- R8: In the arithmetic family, `grpGen`=1 exactly when the x and y adder terms alone carry out of the top bit. `grpProp`=1 exactly when x and y differ in every bit. `carryOut` = `grpGen` | (`grpProp` & carry into bit 0), so the two group flags are never both 1.
- R9: Two slices running code 0, with the lower slice's `carryOut` wired to the upper slice's `carryIn`, produce the correct 2·WIDTH-bit sum and carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opSel | input | 5 | Family bit [4] and operation code [3:0] |
| aIn | input | WIDTH | Operand A |
| bIn | input | WIDTH | Operand B |
| carryIn | input | 1 | Carry into bit 0 for codes that use it |
| result | output | WIDTH | Operation result |
| carryOut | output | 1 | Carry out of the top bit |
| grpGen | output | 1 | Group generate of the adder terms |
| grpProp | output | 1 | Group propagate of the adder terms |

## Verification
The slice holds no state, so every output is due in the same cycle its inputs are applied. No register stands between selector or operands and result. The bench changes the inputs just after a rising clock edge and samples all outputs at the next falling edge, half a period later, when the combinational paths have settled. The chained pair is checked the same way, because its carry path between slices also has no registers.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    X_A,
    X_NOTA,
    X_ZERO,
    X_ONES
  } xSel_e;

  typedef enum logic [2:0] {
    Y_B,
    Y_NOTB,
    Y_ZERO,
    Y_A,
    Y_ONES
  } ySel_e;

  typedef enum logic [1:0] {
    C_EXT,
    C_ZERO,
    C_ONE
  } cSel_e;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_INC   = 4'd2,
    OP_DEC   = 4'd3,
    OP_NEGA  = 4'd4,
    OP_RSUB  = 4'd5,
    OP_NEGB  = 4'd6,
    OP_DBL   = 4'd7,
    OP_ZERO  = 4'd8,
    OP_ONE   = 4'd9,
    OP_MONE  = 4'd10
  } arithOp_e;

  typedef struct packed {
    logic  logicMode;
    xSel_e xSel;
    ySel_e ySel;
    cSel_e cSel;
  } aluCtrl_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0] opSel,
  output aluCtrl_t   ctrl
);

  logic [3:0] code;
  assign code = opSel[3:0];

  always_comb begin
    ctrl.logicMode = ~opSel[4];
    ctrl.xSel      = X_ZERO;
    ctrl.ySel      = Y_ZERO;
    ctrl.cSel      = C_ZERO;
    if (opSel[4]) begin
      case (code)
        OP_ADD:  begin ctrl.xSel = X_A;    ctrl.ySel = Y_B;    ctrl.cSel = C_EXT;  end
        OP_SUB:  begin ctrl.xSel = X_A;    ctrl.ySel = Y_NOTB; ctrl.cSel = C_EXT;  end
        OP_INC:  begin ctrl.xSel = X_A;    ctrl.ySel = Y_ZERO; ctrl.cSel = C_ONE;  end
        OP_DEC:  begin ctrl.xSel = X_A;    ctrl.ySel = Y_ONES; ctrl.cSel = C_ZERO; end
        OP_NEGA: begin ctrl.xSel = X_NOTA; ctrl.ySel = Y_ZERO; ctrl.cSel = C_ONE;  end
        OP_RSUB: begin ctrl.xSel = X_NOTA; ctrl.ySel = Y_B;    ctrl.cSel = C_ONE;  end
        OP_NEGB: begin ctrl.xSel = X_ZERO; ctrl.ySel = Y_NOTB; ctrl.cSel = C_ONE;  end
        OP_DBL:  begin ctrl.xSel = X_A;    ctrl.ySel = Y_A;    ctrl.cSel = C_EXT;  end
        OP_ZERO: begin ctrl.xSel = X_ZERO; ctrl.ySel = Y_ZERO; ctrl.cSel = C_ZERO; end
        OP_ONE:  begin ctrl.xSel = X_ZERO; ctrl.ySel = Y_ZERO; ctrl.cSel = C_ONE;  end
        OP_MONE: begin ctrl.xSel = X_ONES; ctrl.ySel = Y_ZERO; ctrl.cSel = C_ZERO; end
        default: begin ctrl.xSel = X_ZERO; ctrl.ySel = Y_ZERO; ctrl.cSel = C_ZERO; end
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  aluCtrl_t          ctrl,
  input  logic [3:0]        truthTbl,
  input  logic [WIDTH-1:0]  aIn,
  input  logic [WIDTH-1:0]  bIn,
  input  logic              carryIn,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut,
  output logic              grpGen,
  output logic              grpProp
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] xTerm, yTerm, pBit, gBit, sumBits, logicBits;
  logic [WIDTH:0]   carry, genAcc;
  logic             cZero;

  always_comb begin
    case (ctrl.xSel)
      X_A:     xTerm = aIn;
      X_NOTA:  xTerm = ~aIn;
      X_ONES:  xTerm = ALL_ONES;
      default: xTerm = '0;
    endcase
    case (ctrl.ySel)
      Y_B:     yTerm = bIn;
      Y_NOTB:  yTerm = ~bIn;
      Y_A:     yTerm = aIn;
      Y_ONES:  yTerm = ALL_ONES;
      default: yTerm = '0;
    endcase
    case (ctrl.cSel)
      C_EXT:   cZero = carryIn;
      C_ONE:   cZero = 1'b1;
      default: cZero = 1'b0;
    endcase
  end

  assign carry[0]  = cZero;
  assign genAcc[0] = 1'b0;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pBit[i]      = xTerm[i] ^ yTerm[i];
    assign gBit[i]      = xTerm[i] & yTerm[i];
    assign carry[i+1]   = gBit[i] | (pBit[i] & carry[i]);
    assign genAcc[i+1]  = gBit[i] | (pBit[i] & genAcc[i]);
    assign sumBits[i]   = pBit[i] ^ carry[i];
    assign logicBits[i] = truthTbl[{aIn[i], bIn[i]}];
  end

  always_comb begin
    if (ctrl.logicMode) begin
      result   = logicBits;
      carryOut = 1'b0;
      grpGen   = 1'b0;
      grpProp  = 1'b0;
    end else begin
      result   = sumBits;
      carryOut = carry[WIDTH];
      grpGen   = genAcc[WIDTH];
      grpProp  = &pBit;
    end
  end

endmodule

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [4:0]       opSel,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             grpGen,
  output logic             grpProp
);

  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .ctrl     (ctrl),
    .truthTbl (opSel[3:0]),
    .aIn      (aIn),
    .bIn      (bIn),
    .carryIn  (carryIn),
    .result   (result),
    .carryOut (carryOut),
    .grpGen   (grpGen),
    .grpProp  (grpProp)
  );

endmodule

// File: rtl/alu_slice_chk.sv
module alu_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic [4:0]       opSel,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] bIn,
  input logic             carryIn,
  input logic [WIDTH-1:0] result,
  input logic             carryOut,
  input logic             grpGen,
  input logic             grpProp
);

  logic [WIDTH:0] addRef, subRef;
  assign addRef = {1'b0, aIn} + {1'b0, bIn} + {{WIDTH{1'b0}}, carryIn};
  assign subRef = {1'b0, aIn} - {1'b0, bIn};

  always_comb begin
    // R3: logic family clears all carry flags
    if (!opSel[4])
      a_r3_logic_flags_low: assert (!carryOut && !grpGen && !grpProp);
    // R2: XOR code gives bitwise XOR
    if (opSel == 5'b00110)
      a_r2_xor_code: assert (result == (aIn ^ bIn));
    // R4: add code matches operand sum with carry
    if (opSel == 5'b10000)
      a_r4_add_sum: assert ({carryOut, result} == addRef);
    // R5: subtract with carry-in 1 gives difference
    if (opSel == 5'b10001 && carryIn)
      a_r5_sub_diff: assert (result == subRef[WIDTH-1:0]);
    // R8: generate forces carry out, and never with propagate
    a_r8_gen_forces_carry: assert (!grpGen || carryOut);
    a_r8_gen_prop_exclusive: assert (!(grpGen && grpProp));
  end

endmodule

bind alu_slice alu_slice_chk #(.WIDTH(WIDTH)) u_chk (
  .opSel    (opSel),
  .aIn      (aIn),
  .bIn      (bIn),
  .carryIn  (carryIn),
  .result   (result),
  .carryOut (carryOut),
  .grpGen   (grpGen),
  .grpProp  (grpProp)
);

// File: tb/alu_slice_tb.sv
module alu_slice_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0]   opSel;
  logic [W-1:0] aIn, bIn, result;
  logic         carryIn, carryOut, grpGen, grpProp;

  logic [4:0]   hiOp;
  logic [W-1:0] hiA, hiB, hiRes;
  logic         hiCout, hiG, hiP;

  int total = 0;
  int bad   = 0;

  alu_slice #(.WIDTH(W)) u_dut (
    .opSel(opSel), .aIn(aIn), .bIn(bIn), .carryIn(carryIn),
    .result(result), .carryOut(carryOut), .grpGen(grpGen), .grpProp(grpProp)
  );

  // upper slice of the R9 chain, carry taken from u_dut
  alu_slice #(.WIDTH(W)) u_hi (
    .opSel(hiOp), .aIn(hiA), .bIn(hiB), .carryIn(carryOut),
    .result(hiRes), .carryOut(hiCout), .grpGen(hiG), .grpProp(hiP)
  );

  // expected {carryOut, grpGen, grpProp, result}
  function automatic logic [W+2:0] model(input logic [4:0] op, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic ci);
    logic [W-1:0] x, y, r;
    logic         c0;
    logic [W:0]   s, gsum;
    if (!op[4]) begin
      for (int i = 0; i < W; i++) r[i] = op[2*a[i] + b[i]];
      return {3'b000, r};
    end
    case (op[3:0])
      4'd0:  begin x = a;    y = b;    c0 = ci;   end
      4'd1:  begin x = a;    y = ~b;   c0 = ci;   end
      4'd2:  begin x = a;    y = '0;   c0 = 1'b1; end
      4'd3:  begin x = a;    y = ONES; c0 = 1'b0; end
      4'd4:  begin x = ~a;   y = '0;   c0 = 1'b1; end
      4'd5:  begin x = ~a;   y = b;    c0 = 1'b1; end
      4'd6:  begin x = '0;   y = ~b;   c0 = 1'b1; end
      4'd7:  begin x = a;    y = a;    c0 = ci;   end
      4'd9:  begin x = '0;   y = '0;   c0 = 1'b1; end
      4'd10: begin x = ONES; y = '0;   c0 = 1'b0; end
      default: begin x = '0; y = '0;   c0 = 1'b0; end
    endcase
    s    = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c0};
    gsum = {1'b0, x} + {1'b0, y};
    return {s[W], gsum[W], ((x ^ y) == ONES), s[W-1:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s op=%b a=%h b=%h ci=%b got=%h exp=%h", tag, opSel, aIn, bIn, carryIn, got, exp);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci);
    @(posedge clk);
    opSel = op; aIn = a; bIn = b; carryIn = ci;
    @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    chk(tag, {25'd0, carryOut, grpGen, grpProp, result}, {25'd0, model(opSel, aIn, bIn, carryIn)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W+2:0] ref0, ref1;
    void'($urandom(32'd1234));
    opSel = '0; aIn = '0; bIn = '0; carryIn = 1'b0;
    hiOp = 5'b10000; hiA = '0; hiB = '0;
    @(negedge clk);
    chk("R1 idle zero", {28'd0, carryOut, grpGen, grpProp, |result}, 32'd0);

    // R2 named logic codes
    apply(5'b01000, 4'b1100, 4'b1010, 1'b0); chk("R2 AND", result, 4'b1000);
    apply(5'b01110, 4'b1100, 4'b1010, 1'b0); chk("R2 OR",  result, 4'b1110);
    apply(5'b00110, 4'b1100, 4'b1010, 1'b0); chk("R2 XOR", result, 4'b0110);
    apply(5'b00101, 4'b1100, 4'b1010, 1'b0); chk("R2 NOTB", result, 4'b0101);
    // R3 carryIn has no effect in logic family
    apply(5'b01110, 4'b1111, 4'b1111, 1'b1); ref0 = {carryOut, grpGen, grpProp, result};
    apply(5'b01110, 4'b1111, 4'b1111, 1'b0); ref1 = {carryOut, grpGen, grpProp, result};
    chk("R3 carryIn ignored", {25'd0, ref0}, {25'd0, ref1});
    chk("R3 flags low", {29'd0, ref0[W+2:W]}, 32'd0);
    // R4 add of 101+110 = 1011, and doubling
    apply(5'b10000, 4'b0101, 4'b0110, 1'b0); chk("R4 add", {carryOut, result}, 5'b01011);
    apply(5'b10111, 4'b1001, 4'b0000, 1'b1); chk("R4 double", {carryOut, result}, 5'b10011);
    // R5 subtract
    apply(5'b10001, 4'd3, 4'd5, 1'b1); chk("R5 sub borrow", {carryOut, result}, 5'b01110);
    apply(5'b10001, 4'd9, 4'd2, 1'b1); chk("R5 sub", {carryOut, result}, 5'b10111);
    // R6 fixed-carry forms, carryIn set to show it is ignored
    apply(5'b10010, 4'hF, 4'h0, 1'b1); chk("R6 inc wrap", {carryOut, result}, 5'b10000);
    apply(5'b10011, 4'h0, 4'h0, 1'b1); chk("R6 dec wrap", {carryOut, result}, 5'b01111);
    apply(5'b10100, 4'h1, 4'h0, 1'b1); chk("R6 neg A", result, 4'hF);
    apply(5'b10101, 4'h2, 4'h7, 1'b1); chk("R6 B minus A", result, 4'h5);
    apply(5'b10110, 4'h0, 4'h3, 1'b1); chk("R6 neg B", result, 4'hD);
    // R7 constants
    apply(5'b11000, 4'hA, 4'h5, 1'b1); checkAll("R7 zero");
    apply(5'b11001, 4'hA, 4'h5, 1'b1); chk("R7 plus one", result, 4'h1);
    apply(5'b11010, 4'hA, 4'h5, 1'b1); chk("R7 minus one", result, 4'hF);
    apply(5'b11111, 4'hF, 4'hF, 1'b1); chk("R7 unused code", {carryOut, grpGen, grpProp, result}, 7'd0);
    // R8 group flags
    apply(5'b10000, 4'b1010, 4'b0101, 1'b1); chk("R8 propagate", {carryOut, grpGen, grpProp}, 3'b101);
    apply(5'b10000, 4'b1000, 4'b1000, 1'b0); chk("R8 generate", {carryOut, grpGen, grpProp}, 3'b110);

    // random mix over all codes, R1 to R8
    for (int n = 0; n < 3000; n++) begin
      apply(5'($urandom), W'($urandom), W'($urandom), 1'($urandom));
      checkAll("R8 random");
    end

    // R9 chained 8-bit add
    for (int n = 0; n < 300; n++) begin
      logic [2*W-1:0] a8, b8;
      logic           c8;
      logic [2*W:0]   s8;
      a8 = (2*W)'($urandom); b8 = (2*W)'($urandom); c8 = 1'($urandom);
      if (n == 0) begin a8 = '1; b8 = '0; c8 = 1'b1; end
      @(posedge clk);
      opSel = 5'b10000; aIn = a8[W-1:0]; bIn = b8[W-1:0]; carryIn = c8;
      hiA = a8[2*W-1:W]; hiB = b8[2*W-1:W];
      @(negedge clk);
      s8 = {1'b0, a8} + {1'b0, b8} + {{(2*W){1'b0}}, c8};
      chk("R9 chain", {23'd0, hiCout, hiRes, result}, {23'd0, s8});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule